// File: doc/BRIEF.md
# Gated Sub-Chain Scan Shift Controller

This block drives scan shifting for one core. The core's scan flip-flops are split into several sub-chains, and the block models those flip-flops itself. During a shift, only one sub-chain receives a clock enable. The scan input is steered into the head of that sub-chain, and the scan output is taken from its tail. The sub-chains are loaded strictly one after another, so only a fraction of the flip-flops toggle in any cycle. With N sub-chains, shift switching activity falls to about 1/N. A full pattern still takes exactly as many shift cycles as the sum of the sub-chain lengths, the same as a single ungated chain.

A capture cycle enables every sub-chain at once so that each flip-flop takes the core's response. A hold input can freeze shifting at any cycle within a pattern. When hold is released, shifting continues from the same position. Nothing is saved or restored, and no cycles are lost. A one-cycle pattern-done pulse marks the end of each fully shifted pattern.

Top module: `scg_shift_ctrl`

## Requirements
- R1: After reset, all `seg_ce` bits are 0, `pat_done` is 0, `cell_q` is all zero and `scan_out` is 0. The next shift cycle addresses sub-chain 0.
- R2: In a shift cycle (`shift_en`=1, `hold`=0), exactly one bit of `seg_ce` is 1.
- R3: Shift cycles enable sub-chain 0 first, then 1, and so on up to the last sub-chain, then wrap back to sub-chain 0. Sub-chain k is enabled for exactly its length L_k consecutive shift cycles. Sub-chain k occupies `cell_q` bits [O_k+L_k-1 : O_k], where O_k is the sum of the lengths of the lower-numbered sub-chains.
- R4: In a shift cycle on sub-chain k, the cells of that sub-chain move one place toward O_k, and `scan_in` enters at bit O_k+L_k-1. During the cycle, `scan_out` equals `cell_q[O_k]`, which is the bit leaving the chain. As a result, a full pattern of bits s_0..s_(T-1) leaves `cell_q[j]`=s_j. The scan output over that pattern shows the previous `cell_q[0]`..`cell_q[T-1]` in that order.
- R5: A pattern is exactly T = sum of L_k shift cycles. `pat_done` is 1 for exactly one cycle, the cycle that follows the edge ending the last shift cycle of the last sub-chain.
- R6: While `hold`=1, all `seg_ce` bits are 0. `cell_q`, the shift position and `scan_out` stay unchanged whatever `shift_en`, `capture` and `scan_in` do. After release, the pattern still finishes after exactly T shift cycles in total.
- R7: In a capture cycle (`shift_en`=0, `capture`=1, `hold`=0), every `seg_ce` bit is 1 and `cell_q` takes `cap_d` at the edge. The shift position is not changed.
- R8: With `shift_en`=0, `capture`=0 and `hold`=0, all `seg_ce` bits are 0 and `cell_q` holds.
- R9: When `shift_en` and `capture` are both 1 (and `hold`=0), the cycle is a shift cycle and `cap_d` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift request for this cycle |
| capture | input | 1 | Capture request, used when shift_en is 0 |
| hold | input | 1 | Pause; freezes position, cells and enables |
| scan_in | input | 1 | Serial scan data in |
| cap_d | input | TOTAL | Core response captured into the cells |
| scan_out | output | 1 | Tail bit of the currently addressed sub-chain |
| seg_ce | output | NUM_SEG | Per-sub-chain clock enable |
| cell_q | output | TOTAL | Scan cell contents driven to the core |
| pat_done | output | 1 | One-cycle pulse after a complete pattern |

## Verification
The bench builds the block with its default three sub-chains of lengths 10, 5 and 4, for 19 cells in all. Because the lengths are unequal, each sub-chain wraps its counter at a different value, and an off-by-one at any boundary moves the enable and the outgoing bit to the wrong place. Holds are placed both in the middle of a sub-chain and exactly at a boundary, while capture and scan data toggle. This exposes any position loss on resume and any leak of a held or overridden capture. Several back-to-back patterns check the wrap from the last sub-chain to the first and the timing of the done pulse.

// File: rtl/scg_pkg.sv
package scg_pkg;
  localparam int SEG_LW  = 8;
  localparam int SEG_MAX = 16;

  typedef logic [SEG_MAX*SEG_LW-1:0] lens_t;

  // length of sub-chain k
  function automatic int seg_len(input lens_t lens, input int k);
    return int'(lens[k*SEG_LW +: SEG_LW]);
  endfunction

  // first cell index of sub-chain k
  function automatic int seg_off(input lens_t lens, input int k);
    int s;
    s = 0;
    for (int i = 0; i < k; i++) s += seg_len(lens, i);
    return s;
  endfunction

  // number of cells in the first n sub-chains
  function automatic int total_len(input lens_t lens, input int n);
    return seg_off(lens, n);
  endfunction
endpackage

// File: rtl/scg_seq.sv
module scg_seq #(
  parameter int           NUM_SEG  = 3,
  parameter scg_pkg::lens_t SEG_LENS = scg_pkg::lens_t'({8'd4, 8'd5, 8'd10}),
  localparam int          IW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int          CW = scg_pkg::SEG_LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          hold,
  output logic [IW-1:0] idx,
  output logic          seg_end,
  output logic          pat_done
);
  logic [CW-1:0] cnt;
  logic          wrap;
  int            cur_len;

  assign cur_len = scg_pkg::seg_len(SEG_LENS, int'(idx));
  assign seg_end = step && (cnt == CW'(cur_len - 1));
  assign wrap    = seg_end && (idx == IW'(NUM_SEG - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      idx      <= '0;
      pat_done <= 1'b0;
    end else begin
      pat_done <= wrap;
      if (step) begin
        if (seg_end) begin
          cnt <= '0;
          idx <= wrap ? '0 : idx + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  seg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_end |=> idx == (($past(idx) == IW'(NUM_SEG - 1)) ? '0 : $past(idx) + 1'b1));
  // R3
  seg_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !seg_end) |=> $stable(idx));
  // R6
  hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(idx) && $stable(cnt)));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_done |=> !pat_done);
endmodule

// File: rtl/scg_segment.sv
module scg_segment #(
  parameter int LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic           load,
  input  logic           sin,
  input  logic [LEN-1:0] d,
  output logic [LEN-1:0] q
);
  logic [LEN-1:0] shifted;

  generate
    if (LEN == 1) begin : g_one
      assign shifted = sin;
    end else begin : g_many
      assign shifted = {sin, q[LEN-1:1]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= load ? d : shifted;
  end

  // R6
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q));
  // R7
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && load) |=> (q == $past(d)));
  // R4
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !load) |=> (q[LEN-1] == $past(sin)));
endmodule

// File: rtl/scg_shift_ctrl.sv
module scg_shift_ctrl #(
  parameter int             NUM_SEG  = 3,
  parameter scg_pkg::lens_t SEG_LENS = scg_pkg::lens_t'({8'd4, 8'd5, 8'd10}),
  localparam int            TOTAL = scg_pkg::total_len(SEG_LENS, NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               capture,
  input  logic               hold,
  input  logic               scan_in,
  input  logic [TOTAL-1:0]   cap_d,
  output logic               scan_out,
  output logic [NUM_SEG-1:0] seg_ce,
  output logic [TOTAL-1:0]   cell_q,
  output logic               pat_done
);
  localparam int IW = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  logic          shift_mode;
  logic          cap_mode;
  logic [IW-1:0] idx;
  logic          seg_end;
  logic [NUM_SEG-1:0] seg_tail;

  assign shift_mode = shift_en && !hold;
  assign cap_mode   = !shift_en && capture && !hold;

  scg_seq #(.NUM_SEG(NUM_SEG), .SEG_LENS(SEG_LENS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (shift_mode),
    .hold     (hold),
    .idx      (idx),
    .seg_end  (seg_end),
    .pat_done (pat_done)
  );

  generate
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
      localparam int OFF = scg_pkg::seg_off(SEG_LENS, k);
      localparam int LEN = scg_pkg::seg_len(SEG_LENS, k);

      assign seg_ce[k]   = cap_mode || (shift_mode && (idx == IW'(k)));
      assign seg_tail[k] = cell_q[OFF];

      scg_segment #(.LEN(LEN)) u_seg (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (seg_ce[k]),
        .load  (cap_mode),
        .sin   (scan_in),
        .d     (cap_d[OFF +: LEN]),
        .q     (cell_q[OFF +: LEN])
      );
    end
  endgenerate

  always_comb begin
    scan_out = 1'b0;
    for (int k = 0; k < NUM_SEG; k++)
      if (idx == IW'(k)) scan_out = seg_tail[k];
  end

  // R2
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_mode |-> $onehot(seg_ce));
  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture) |-> (seg_ce == '0));
  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(scan_out));
endmodule

// File: tb/test_scg_shift_ctrl.sv
`timescale 1ns/1ps
module test_scg_shift_ctrl;
  localparam int NSEG = 3;
  localparam int TOT  = 19;
  localparam int LENS [NSEG] = '{10, 5, 4};
  localparam int OFFS [NSEG] = '{0, 10, 15};

  logic clk = 1'b0, rst_n = 1'b0;
  logic shift_en = 1'b0, capture = 1'b0, hold = 1'b0, scan_in = 1'b0;
  logic [TOT-1:0]  cap_d = '0;
  logic            scan_out, pat_done;
  logic [NSEG-1:0] seg_ce;
  logic [TOT-1:0]  cell_q;

  always #2 clk = ~clk;

  scg_shift_ctrl i_scg_shift_ctrl (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .capture(capture),
    .hold(hold), .scan_in(scan_in), .cap_d(cap_d), .scan_out(scan_out),
    .seg_ce(seg_ce), .cell_q(cell_q), .pat_done(pat_done)
  );

  typedef struct packed {
    logic [NSEG-1:0] ce;
    logic            so;
    logic            dn;
    logic [TOT-1:0]  cells;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  smp_ev;
  int    n_vec = 0, n_bad = 0;

  logic [TOT-1:0] mdl = '0;
  int   pos = 0;
  logic done_nx = 1'b0;

  function automatic int seg_of(input int p);
    for (int k = 0; k < NSEG; k++)
      if (p < OFFS[k] + LENS[k]) return k;
    return 0;
  endfunction

  // driver: one cycle of stimulus, expectation pushed to the scoreboard
  task automatic cyc(input logic sh, input logic cp, input logic hd,
                     input logic si, input logic [TOT-1:0] cd, input string tag);
    exp_t e;
    int   k;
    @(negedge clk);
    shift_en = sh; capture = cp; hold = hd; scan_in = si; cap_d = cd;
    k       = seg_of(pos);
    e.ce    = hd ? '0 : sh ? NSEG'(1 << k) : cp ? '1 : '0;
    e.so    = mdl[OFFS[k]];
    e.dn    = done_nx;
    e.cells = mdl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> smp_ev;
    done_nx = 1'b0;
    if (!hd && sh) begin
      for (int i = OFFS[k]; i < OFFS[k] + LENS[k] - 1; i++) mdl[i] = mdl[i+1];
      mdl[OFFS[k] + LENS[k] - 1] = si;
      pos++;
      if (pos == TOT) begin pos = 0; done_nx = 1'b1; end
    end else if (!hd && cp) begin
      mdl = cd;
    end
  endtask

  // monitor: compares the design against the queued expectation
  initial forever begin
    exp_t  e;
    string t;
    bit    bad;
    @(smp_ev);
    #1;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_vec++;
    bad = 0;
    if (seg_ce !== e.ce) begin
      bad = 1; $display("FAIL %s seg_ce actual %b expected %b", t, seg_ce, e.ce);
    end
    if (scan_out !== e.so) begin
      bad = 1; $display("FAIL %s scan_out actual %b expected %b", t, scan_out, e.so);
    end
    if (pat_done !== e.dn) begin
      bad = 1; $display("FAIL %s pat_done actual %b expected %b", t, pat_done, e.dn);
    end
    if (cell_q !== e.cells) begin
      bad = 1; $display("FAIL %s cell_q actual %h expected %h", t, cell_q, e.cells);
    end
    if (bad) n_bad++;
  end

  task automatic shift_pat(input logic [TOT-1:0] s, input string tag);
    for (int j = 0; j < TOT; j++) cyc(1, 0, 0, s[j], '0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cyc(0, 0, 0, 0, '0, "R1");                    // reset state
    cyc(0, 0, 0, 1, 19'h7FFFF, "R8");             // idle: nothing moves
    cyc(0, 1, 0, 0, 19'h2B6C5, "R7");             // capture
    cyc(0, 0, 0, 0, '0, "R7");
    shift_pat(19'h5A3C1, "R3/R4");                // full pattern, unload captured data
    cyc(0, 0, 0, 0, '0, "R5");                    // done pulse visible here
    cyc(0, 0, 0, 0, '0, "R5");                    // and gone

    // hold in the middle of sub-chain 0 and exactly on a boundary
    cyc(0, 1, 0, 0, 19'h13579, "R7");
    for (int j = 0; j < 6; j++) cyc(1, 0, 0, j[0], '0, "R2");
    for (int j = 0; j < 3; j++) cyc(1, 1, 1, ~j[0], 19'h7FFFF, "R6");
    for (int j = 6; j < 10; j++) cyc(1, 0, 0, j[1], '0, "R3");
    cyc(0, 1, 1, 1, 19'h7FFFF, "R6");             // capture under hold ignored
    cyc(0, 1, 1, 0, 19'h00000, "R6");
    for (int j = 10; j < 15; j++) cyc(1, 1, 0, j[0], 19'h7FFFF, "R9");
    cyc(0, 0, 0, 1, '0, "R8");
    for (int j = 15; j < TOT; j++) cyc(1, 0, 0, ~j[0], '0, "R4");
    cyc(1, 0, 1, 0, '0, "R5");                    // done pulse during hold
    cyc(0, 0, 0, 0, '0, "R5");

    // back-to-back patterns across the wrap
    for (int p = 0; p < 4; p++) begin
      logic [TOT-1:0] v;
      v = TOT'($urandom);
      if (p == 2) cyc(0, 1, 0, 0, TOT'($urandom), "R7");
      shift_pat(v, "R5");
    end
    cyc(0, 0, 0, 0, '0, "R5");
    cyc(0, 0, 0, 0, '0, "R4");

    @(negedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule